// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches a running BCD calendar and raises an alarm when the calendar reaches a programmed moment. The calendar counter sits outside the block. Its six fields (seconds, minutes, hours, date, month and weekday) arrive as inputs, together with a one-cycle tick that marks each new second. Six alarm registers, one per field, each hold an enable bit and a BCD compare value. A field whose enable is clear takes no part in the compare.

A match is evaluated only in the cycle where the second tick is high. At that point the calendar inputs already show the new time. A match sets a status flag and pulls an active-low interrupt output down. In latched mode the interrupt stays low until the host clears the flag. The host clears it either by writing zero to it or, when the auto-clear control bit is set, by reading the status location. In pulsed mode every match produces a fixed-width low pulse, and the flag never has to be serviced.

A small write/read port with an address, write and read strobes, and combinational read data gives the host access to the alarm registers, the status flag and the control bits.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset, the status flag is 0, `irq_n` is 1, and every alarm and control register reads 0.
- R2: Addresses 0 to 5 hold the alarm registers for seconds, minutes, hours, date, month and weekday, in that order, and read back exactly what was written. Address 7 is control: bit 0 selects pulsed mode and bit 1 enables clear-on-read. Only those two bits are stored, and the other bits read 0. Address 6 reads the status flag in bit 0, with the other bits reading 0.
- R3: Bit 7 of an alarm register enables its field, and an enabled field matches when bits 6:0 of the register equal the calendar field. An alarm fires only when every enabled field matches. Disabled fields are ignored.
- R4: Matching is evaluated only in a cycle with `sec_tick` high. The flag reads 1 from the clock edge that samples the matching tick. A matching calendar with no tick never sets the flag.
- R5: With all six enable bits clear, the alarm never fires for any calendar value.
- R6: In latched mode (control bit 0 = 0), `irq_n` is low exactly while the flag is 1. It returns high in the cycle after the flag is cleared.
- R7: Writing status with bit 0 = 0 clears the flag at the next edge. Writing status with bit 0 = 1 leaves the flag unchanged.
- R8: With control bit 1 set, a status read returns the flag as it was and clears the flag at the next edge. With control bit 1 clear, a read leaves the flag unchanged.
- R9: In pulsed mode, each match drives `irq_n` low for exactly PULSE_CYC cycles, starting at the edge that samples the tick. The flag is set but needs no service, and later matches pulse again. With only seconds = 30 enabled, one pulse occurs per 60 ticks.
- R10: If a match and a flag-clearing access occur in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe marking a new second |
| cal_sec | input | 8 | Calendar seconds, BCD |
| cal_min | input | 8 | Calendar minutes, BCD |
| cal_hour | input | 8 | Calendar hours, BCD |
| cal_date | input | 8 | Calendar date, BCD |
| cal_month | input | 8 | Calendar month, BCD |
| cal_wday | input | 8 | Calendar weekday |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| alarm_flag | output | 1 | Status alarm flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check on every cycle that a match never fires without a tick and never fires with all fields disabled. They also check that a match sets the flag, that clearing writes and clear-on-read act at the next edge with set winning over clear, and that a match drives the interrupt low in both modes. Only the bench scenarios can show the full match function. It sweeps a whole minute of seconds against a single enabled field and sweeps multi-field combinations against a model computed in the bench. The bench also measures the exact pulse width, the spacing of one pulse per 60 ticks, and the register readback values.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned NUM_FIELDS  = 6;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned ADDR_W      = 3;
  localparam int unsigned EN_BIT      = DATA_W - 1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd7;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [NUM_FIELDS-1:0][DATA_W-1:0] fields_t;

  // A field passes when disabled or when its compare value equals the calendar.
  function automatic logic field_pass(input byte_t areg, input byte_t cval);
    logic en;
    byte_t cmp;
    en  = areg[EN_BIT];
    cmp = {1'b0, areg[EN_BIT-1:0]};
    return (!en) || (cmp == cval);
  endfunction

  function automatic logic field_enabled(input byte_t areg);
    return areg[EN_BIT];
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  byte_t             reg_wdata,
  input  logic              flag,
  output byte_t             reg_rdata,
  output fields_t           alarm_regs,
  output logic              mode_pulsed,
  output logic              auto_clr,
  output logic              st_wr_clr,
  output logic              st_rd_clr
);
  logic [1:0] ctrl_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_areg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          alarm_regs[gi] <= '0;
        else if (reg_wr && (reg_addr == ADDR_W'(gi)))
          alarm_regs[gi] <= reg_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (reg_wr && (reg_addr == ADDR_CTRL))
      ctrl_q <= reg_wdata[1:0];
  end

  assign mode_pulsed = ctrl_q[0];
  assign auto_clr    = ctrl_q[1];
  assign st_wr_clr   = reg_wr && (reg_addr == ADDR_STATUS) && !reg_wdata[0];
  assign st_rd_clr   = reg_rd && (reg_addr == ADDR_STATUS) && auto_clr;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_STATUS)
      reg_rdata = {{(DATA_W-1){1'b0}}, flag};
    else if (reg_addr == ADDR_CTRL)
      reg_rdata = {{(DATA_W-2){1'b0}}, ctrl_q};
    else
      reg_rdata = alarm_regs[reg_addr];
  end
endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
  import cal_alarm_pkg::*;
(
  input  fields_t                alarm_regs,
  input  fields_t                cal_now,
  input  logic                   sec_tick,
  output logic [NUM_FIELDS-1:0]  en_mask,
  output logic [NUM_FIELDS-1:0]  pass_mask,
  output logic                   fire
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_fld
      assign en_mask[gi]   = field_enabled(alarm_regs[gi]);
      assign pass_mask[gi] = field_pass(alarm_regs[gi], cal_now[gi]);
    end
  endgenerate

  assign fire = sec_tick && (|en_mask) && (&pass_mask);
endmodule

// File: rtl/alarm_irq_ctl.sv
module alarm_irq_ctl #(
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic mode_pulsed,
  input  logic st_wr_clr,
  input  logic st_rd_clr,
  output logic flag,
  output logic irq_n
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] pulse_cnt;
  logic             pulse_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (fire)
      flag <= 1'b1;
    else if (st_wr_clr || st_rd_clr)
      flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pulse_cnt <= '0;
    else if (fire && mode_pulsed)
      pulse_cnt <= CNT_LOAD;
    else if (pulse_cnt != '0)
      pulse_cnt <= pulse_cnt - 1'b1;
  end

  assign pulse_on = (pulse_cnt != '0);
  assign irq_n    = mode_pulsed ? !pulse_on : !flag;
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [7:0] cal_sec,
  input  logic [7:0] cal_min,
  input  logic [7:0] cal_hour,
  input  logic [7:0] cal_date,
  input  logic [7:0] cal_month,
  input  logic [7:0] cal_wday,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       alarm_flag,
  output logic       irq_n
);
  fields_t                cal_now;
  fields_t                alarm_regs;
  logic [NUM_FIELDS-1:0]  en_mask;
  logic [NUM_FIELDS-1:0]  pass_mask;
  logic                   fire_w;
  logic                   mode_pulsed;
  logic                   auto_clr;
  logic                   st_wr_clr;
  logic                   st_rd_clr;
  logic                   flag_w;

  assign cal_now = {cal_wday, cal_month, cal_date, cal_hour, cal_min, cal_sec};

  alarm_regfile u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .flag        (flag_w),
    .reg_rdata   (reg_rdata),
    .alarm_regs  (alarm_regs),
    .mode_pulsed (mode_pulsed),
    .auto_clr    (auto_clr),
    .st_wr_clr   (st_wr_clr),
    .st_rd_clr   (st_rd_clr)
  );

  alarm_matcher u_match (
    .alarm_regs (alarm_regs),
    .cal_now    (cal_now),
    .sec_tick   (sec_tick),
    .en_mask    (en_mask),
    .pass_mask  (pass_mask),
    .fire       (fire_w)
  );

  alarm_irq_ctl #(.PULSE_CYC(PULSE_CYC)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire_w),
    .mode_pulsed (mode_pulsed),
    .st_wr_clr   (st_wr_clr),
    .st_rd_clr   (st_rd_clr),
    .flag        (flag_w),
    .irq_n       (irq_n)
  );

  assign alarm_flag = flag_w;
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       fire,
  input logic [5:0] en_mask,
  input logic       flag,
  input logic       irq_n,
  input logic       mode_pulsed,
  input logic       st_wr_clr,
  input logic       st_rd_clr,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata
);
  assert_fire_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> sec_tick);

  assert_fire_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag);

  assert_no_fire_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask == 6'd0) |-> !fire);

  assert_wr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_clr && !fire) |=> !flag);

  assert_wr_one_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd6 && reg_wdata[0] && flag) |=> flag);

  assert_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd_clr && !fire) |=> !flag);

  assert_latched_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mode_pulsed && !(reg_wr && reg_addr == 3'd7)) |=> !irq_n);

  assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_pulsed && !(reg_wr && reg_addr == 3'd7)) |=> !irq_n);
endmodule

bind cal_alarm_unit cal_alarm_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_tick    (sec_tick),
  .fire        (fire_w),
  .en_mask     (en_mask),
  .flag        (flag_w),
  .irq_n       (irq_n),
  .mode_pulsed (mode_pulsed),
  .st_wr_clr   (st_wr_clr),
  .st_rd_clr   (st_rd_clr),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata)
);

// File: tb/tb_cal_alarm_unit.sv
`timescale 1ns/1ps
module tb_cal_alarm_unit;
  localparam int PULSE_CYC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] cal_sec = '0, cal_min = '0, cal_hour = '0;
  logic [7:0] cal_date = '0, cal_month = '0, cal_wday = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       alarm_flag, irq_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] alm [6];

  always #10 clk = ~clk;

  cal_alarm_unit #(.PULSE_CYC(PULSE_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
    .cal_date(cal_date), .cal_month(cal_month), .cal_wday(cal_wday),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  // Bench model: every enabled field (value >= 0x80) must equal its calendar value.
  function automatic logic model_hit(input logic [7:0] c0, input logic [7:0] c1,
      input logic [7:0] c2, input logic [7:0] c3, input logic [7:0] c4, input logic [7:0] c5);
    logic [7:0] c [6];
    int nen = 0, nok = 0;
    c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3; c[4] = c4; c[5] = c5;
    for (int i = 0; i < 6; i++) begin
      if (alm[i] >= 8'h80) begin
        nen++;
        if ((alm[i] - 8'h80) == c[i]) nok++;
      end
    end
    return (nen > 0) && (nen == nok);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_alarm(input int i, input logic [7:0] v);
    alm[i] = v;
    wr(3'(i), v);
  endtask

  task automatic do_tick(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
      input logic [7:0] d, input logic [7:0] mo, input logic [7:0] w);
    @(negedge clk);
    cal_sec = s; cal_min = m; cal_hour = h; cal_date = d; cal_month = mo; cal_wday = w;
    sec_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  initial begin
    #(20.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    int pulses, width, errs;
    for (int i = 0; i < 6; i++) alm[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(alarm_flag == 1'b0, "R1 flag", alarm_flag, 0);
    check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
    errs = 0;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv);
      if (rv != 8'h00) errs++;
    end
    check(errs == 0, "R1 regs zero", errs, 0);

    // R2 readback
    for (int a = 0; a < 6; a++) set_alarm(a, 8'h11 * a + 8'h05);
    errs = 0;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), rv);
      if (rv != 8'h11 * a + 8'h05) errs++;
    end
    check(errs == 0, "R2 alarm readback", errs, 0);
    wr(3'd7, 8'hFC);
    rd(3'd7, rv);
    check(rv == 8'h00, "R2 ctrl upper bits", rv, 0);
    wr(3'd7, 8'h03);
    rd(3'd7, rv);
    check(rv == 8'h03, "R2 ctrl bits", rv, 3);
    wr(3'd7, 8'h00);
    rd(3'd6, rv);
    check(rv == 8'h00, "R2 status idle", rv, 0);

    // R5 all fields disabled
    for (int a = 0; a < 6; a++) set_alarm(a, 8'h00);
    errs = 0;
    for (int s = 0; s < 60; s++) begin
      do_tick(to_bcd(s), 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      if (alarm_flag) errs++;
    end
    check(errs == 0, "R5 never fires", errs, 0);

    // R3/R4/R6/R7 seconds-only sweep, latched mode
    set_alarm(0, 8'hB0);
    errs = 0;
    for (int s = 0; s < 60; s++) begin
      logic e;
      e = model_hit(to_bcd(s), 8'h15, 8'h09, 8'h02, 8'h03, 8'h04);
      do_tick(to_bcd(s), 8'h15, 8'h09, 8'h02, 8'h03, 8'h04);
      if (alarm_flag != e || irq_n != !e) errs++;
      if (e) begin
        wr(3'd6, 8'h00);
        check(alarm_flag == 1'b0, "R7 write 0 clears", alarm_flag, 0);
        check(irq_n == 1'b1, "R6 irq_n released", irq_n, 1);
      end
    end
    check(errs == 0, "R3 R4 R6 seconds sweep", errs, 0);

    // R4 match present but no tick
    @(negedge clk);
    cal_sec = 8'h30;
    repeat (5) @(negedge clk);
    check(alarm_flag == 1'b0, "R4 no tick no fire", alarm_flag, 0);

    // R3 multi-field sweep: min 30, hour 11, date 1, month 1
    set_alarm(0, 8'h00); set_alarm(1, 8'hB0); set_alarm(2, 8'h91);
    set_alarm(3, 8'h81); set_alarm(4, 8'h81); set_alarm(5, 8'h00);
    errs = 0;
    for (int m = 28; m <= 32; m++)
      for (int h = 10; h <= 12; h++)
        for (int d = 1; d <= 2; d++) begin
          logic e;
          e = model_hit(8'h00, to_bcd(m), to_bcd(h), to_bcd(d), 8'h01, 8'h06);
          do_tick(8'h00, to_bcd(m), to_bcd(h), to_bcd(d), 8'h01, 8'h06);
          if (alarm_flag != e) errs++;
          if (alarm_flag) wr(3'd6, 8'h00);
        end
    check(errs == 0, "R3 multi-field", errs, 0);

    // R7 write 1 keeps flag
    do_tick(8'h00, 8'h30, 8'h11, 8'h01, 8'h01, 8'h00);
    wr(3'd6, 8'h01);
    check(alarm_flag == 1'b1, "R7 write 1 keeps", alarm_flag, 1);

    // R8 read without auto-clear keeps
    rd(3'd6, rv);
    check(rv == 8'h01 && alarm_flag == 1'b1, "R8 read no clear", alarm_flag, 1);
    wr(3'd7, 8'h02);
    rd(3'd6, rv);
    check(rv == 8'h01, "R8 read value", rv, 1);
    check(alarm_flag == 1'b0, "R8 clear on read", alarm_flag, 0);
    wr(3'd7, 8'h00);

    // R10 set wins over clear in the same cycle
    @(negedge clk);
    cal_sec = 8'h00; cal_min = 8'h30; cal_hour = 8'h11; cal_date = 8'h01; cal_month = 8'h01;
    sec_tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h00;
    @(posedge clk);
    @(negedge clk);
    sec_tick = 1'b0; reg_wr = 1'b0;
    check(alarm_flag == 1'b1, "R10 set wins", alarm_flag, 1);
    wr(3'd6, 8'h00);

    // R9 pulsed mode, seconds 30 only
    for (int a = 0; a < 6; a++) set_alarm(a, 8'h00);
    set_alarm(0, 8'hB0);
    wr(3'd7, 8'h01);
    do_tick(8'h30, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    width = 0;
    for (int k = 0; k < PULSE_CYC + 3; k++) begin
      if (!irq_n) width++;
      @(negedge clk);
    end
    check(width == PULSE_CYC, "R9 pulse width", width, PULSE_CYC);
    check(alarm_flag == 1'b1, "R9 flag set", alarm_flag, 1);
    pulses = 0;
    for (int t = 0; t < 120; t++) begin
      do_tick(to_bcd(t % 60), 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      if (!irq_n) pulses++;
      repeat (PULSE_CYC) @(negedge clk);
      if (!irq_n) pulses += 100;
    end
    check(pulses == 2, "R9 one pulse per 60 ticks", pulses, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule